// File: doc/BRIEF.md
# Fast Interrupt Request Channel

This block turns one external interrupt input into an active-low fast interrupt request line for a processor. No arbitration is involved because there is only one source. Software picks how the input is recognised: on a rising edge, on a falling edge, while high, or while low. It also stores the address of the handler. The input is first brought into the clock domain by a two-stage synchroniser.

The processor fetches the handler address by reading the fast vector location. That read also acknowledges the interrupt. In the two edge modes the read clears the latched request. In the two level modes the read changes nothing, and the request follows the input until the source itself removes the level. An enable bit gates the output line. Edges that arrive while the channel is disabled are still latched, so they are not lost.

Top module: `firqChannel`

## Requirements
- R1: After reset `firqN` is 1, and the control register (address 0) and the vector register (address 1) both read 0.
- R2: A write to address 1 stores the data with bits [1:0] forced to 0. The stored value reads back at address 1 and also at the fast vector address 2.
- R3: Control address 0 holds the trigger mode in bits [1:0] and the enable in bit 2. With mode 0 (rising edge) and enable 1, `firqN` falls on the third clock edge after `extIn` rises. A falling input does not raise the request.
- R4: With mode 1 (falling edge), `firqN` falls on the third clock edge after `extIn` falls. A rising input does not raise the request.
- R5: With mode 2 (high level), `firqN` is 0 while the synchronised input is 1, two clock edges after the input changes. A read of address 2 does not release it.
- R6: With mode 3 (low level), `firqN` is 0 while the synchronised input is 0, and it returns to 1 two clock edges after the input rises.
- R7: In an edge mode, a read of address 2 (`regRd` with `regSel`=2) clears the latched request, and `firqN` returns to 1 after that clock edge.
- R8: If a qualifying edge is detected in the same cycle as a clearing read, the request stays latched.
- R9: While enable is 0, `firqN` stays 1. An edge seen while disabled is latched, and `firqN` falls as soon as enable is set.
- R10: Reads of addresses 0 and 1 do not acknowledge a latched request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register address (0 control, 1 vector, 2 fast vector) |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe; with address 2 it acknowledges |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for the selected address (combinational) |
| extIn | input | 1 | Asynchronous external interrupt input |
| firqN | output | 1 | Active-low fast interrupt request |

## Verification
A pending flag that is wrongly held or wrongly dropped shows up on `firqN` at the first clock edge after an acknowledge. That makes edge-mode clearing, and the race between a detected edge and a clear, visible within one cycle. A wrong synchroniser depth or a wrong edge reference moves the fall of `firqN` away from the second edge after an input change (level modes) or the third edge (edge modes). Corrupt vector storage appears immediately on the combinational read data at either vector address.

// File: rtl/firqPkg.sv
package firqPkg;

  typedef enum logic [1:0] {
    TRIG_RISE = 2'd0,
    TRIG_FALL = 2'd1,
    TRIG_HIGH = 2'd2,
    TRIG_LOW  = 2'd3
  } trigMode_e;

  localparam int REG_ADDR_W = 2;
  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_VEC  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_FVEC = 2'd2;

  typedef struct packed {
    logic wrCtrl;
    logic wrVec;
    logic ackRead;
  } ctlStrobes_t;

endpackage

// File: rtl/firqControl.sv
module firqControl
  import firqPkg::*;
(
  input  logic [REG_ADDR_W-1:0] regSel,
  input  logic                  regWr,
  input  logic                  regRd,
  input  trigMode_e             modeQ,
  input  logic                  enableQ,
  input  logic                  pendingQ,
  input  logic                  syncIn,
  output ctlStrobes_t           strb,
  output logic                  firqN
);

  logic levelMode;
  logic levelActive;
  logic reqRaw;

  always_comb begin
    strb.wrCtrl  = regWr && (regSel == ADDR_CTRL);
    strb.wrVec   = regWr && (regSel == ADDR_VEC);
    strb.ackRead = regRd && (regSel == ADDR_FVEC);
  end

  assign levelMode   = (modeQ == TRIG_HIGH) || (modeQ == TRIG_LOW);
  assign levelActive = (modeQ == TRIG_HIGH) ? syncIn : !syncIn;

  always_comb begin
    if (levelMode) reqRaw = levelActive;
    else           reqRaw = pendingQ;
  end

  assign firqN = !(enableQ && reqRaw);

endmodule

// File: rtl/firqDatapath.sv
module firqDatapath
  import firqPkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int VEC_ALIGN   = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobes_t           strb,
  input  logic [REG_ADDR_W-1:0] regSel,
  input  logic [DATA_W-1:0]     regWdata,
  input  logic                  extIn,
  output logic [DATA_W-1:0]     regRdata,
  output trigMode_e             modeQ,
  output logic                  enableQ,
  output logic                  pendingQ,
  output logic                  syncIn,
  output logic                  edgeHit
);

  localparam int VEC_HI  = DATA_W - 1;
  localparam int CTRL_EN = 2;

  logic [SYNC_STAGES-1:0]  syncChain;
  logic                    prevIn;
  logic [VEC_HI:VEC_ALIGN] vecQ;
  logic [DATA_W-1:0]       vecFull;
  logic [DATA_W-1:0]       ctrlView;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '0;
    else       syncChain <= {syncChain[SYNC_STAGES-2:0], extIn};
  end

  assign syncIn = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevIn <= 1'b0;
    else       prevIn <= syncIn;
  end

  always_comb begin
    unique case (modeQ)
      TRIG_RISE: edgeHit = syncIn && !prevIn;
      TRIG_FALL: edgeHit = !syncIn && prevIn;
      default:   edgeHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendingQ <= 1'b0;
    else       pendingQ <= edgeHit || (pendingQ && !strb.ackRead && !modeQ[1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= TRIG_RISE;
      enableQ <= 1'b0;
    end else if (strb.wrCtrl) begin
      modeQ   <= trigMode_e'(regWdata[1:0]);
      enableQ <= regWdata[CTRL_EN];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           vecQ <= '0;
    else if (strb.wrVec) vecQ <= regWdata[VEC_HI:VEC_ALIGN];
  end

  assign vecFull  = {vecQ, {VEC_ALIGN{1'b0}}};
  assign ctrlView = {{(DATA_W-CTRL_EN-1){1'b0}}, enableQ, modeQ};

  always_comb begin
    unique case (regSel)
      ADDR_CTRL: regRdata = ctrlView;
      ADDR_VEC,
      ADDR_FVEC: regRdata = vecFull;
      default:   regRdata = '0;
    endcase
  end

endmodule

// File: rtl/firqChannel.sv
module firqChannel
  import firqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        extIn,
  output logic        firqN
);

  ctlStrobes_t strb;
  trigMode_e   modeQ;
  logic        enableQ;
  logic        pendingQ;
  logic        syncIn;
  logic        edgeHit;

  firqControl ctlI (
    .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .modeQ(modeQ), .enableQ(enableQ), .pendingQ(pendingQ),
    .syncIn(syncIn), .strb(strb), .firqN(firqN)
  );

  firqDatapath #(.DATA_W(32), .SYNC_STAGES(2), .VEC_ALIGN(2)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .regSel(regSel),
    .regWdata(regWdata), .extIn(extIn), .regRdata(regRdata),
    .modeQ(modeQ), .enableQ(enableQ), .pendingQ(pendingQ),
    .syncIn(syncIn), .edgeHit(edgeHit)
  );

endmodule

// File: rtl/firqChannelChk.sv
module firqChannelChk
  import firqPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regSel,
  input logic        regRd,
  input logic [31:0] regRdata,
  input logic        firqN,
  input ctlStrobes_t strb,
  input logic        enableQ,
  input logic        pendingQ,
  input logic        edgeHit
);

  // R8
  edge_relatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeHit |=> pendingQ);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackRead && !edgeHit) |=> !pendingQ);

  // R2
  vec_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regSel != 2'd0) |-> (regRdata[1:0] == 2'b00));

  // R10
  ack_decode_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackRead |-> (regRd && regSel == 2'd2));

  // R9
  gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> firqN);

endmodule

bind firqChannel firqChannelChk chkI (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regRd(regRd),
  .regRdata(regRdata), .firqN(firqN), .strb(strb), .enableQ(enableQ),
  .pendingQ(pendingQ), .edgeHit(edgeHit)
);

// File: tb/firqChannel_test.sv
`timescale 1ns/1ps
module firqChannel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        extIn = 1'b0;
  logic        firqN;

  always #5 clk = ~clk;

  firqChannel uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .extIn(extIn), .firqN(firqN)
  );

  typedef struct {
    string       tag;
    bit          isRead;
    logic [31:0] expv;
  } item_t;

  item_t sbq[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      wait (sbq.size() > 0);
      #1;
      begin
        item_t it;
        logic [31:0] act;
        it = sbq.pop_front();
        act = it.isRead ? regRdata : {31'b0, firqN};
        checks++;
        if (act !== it.expv) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.expv);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expIrq(input string tag, input logic v);
    item_t it;
    it.tag = tag; it.isRead = 1'b0; it.expv = {31'b0, v};
    sbq.push_back(it);
    #2;
  endtask

  task automatic expRead(input string tag, input logic [1:0] a, input logic [31:0] v);
    item_t it;
    regSel = a; regRd = 1'b1;
    it.tag = tag; it.isRead = 1'b1; it.expv = v;
    sbq.push_back(it);
    tick(1);
    regRd = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    regSel = a; regWr = 1'b1; regWdata = d;
    tick(1);
    regWr = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    // R1 reset state
    expIrq("R1 firqN after reset", 1'b1);
    expRead("R1 control reads zero", 2'd0, 32'h0);
    expRead("R1 vector reads zero", 2'd1, 32'h0);

    // R2 vector alignment and fast vector mirror
    wrReg(2'd1, 32'h1234_5677);
    expRead("R2 vector readback", 2'd1, 32'h1234_5674);
    expRead("R2 fast vector readback", 2'd2, 32'h1234_5674);

    // R3 rising edge
    wrReg(2'd0, 32'h4);
    extIn = 1'b1;
    tick(2); expIrq("R3 not yet after two edges", 1'b1);
    tick(1); expIrq("R3 asserted on third edge", 1'b0);
    // R10 other reads do not acknowledge
    expRead("R10 control read", 2'd0, 32'h4);
    expRead("R10 vector read", 2'd1, 32'h1234_5674);
    expIrq("R10 still asserted", 1'b0);
    // R7 acknowledge clears
    expRead("R7 fast vector data", 2'd2, 32'h1234_5674);
    expIrq("R7 cleared by read", 1'b1);
    extIn = 1'b0;
    tick(4); expIrq("R3 falling input ignored", 1'b1);

    // R4 falling edge
    wrReg(2'd0, 32'h5);
    extIn = 1'b1;
    tick(4); expIrq("R4 rising input ignored", 1'b1);
    extIn = 1'b0;
    tick(2); expIrq("R4 not yet", 1'b1);
    tick(1); expIrq("R4 asserted on third edge", 1'b0);
    expRead("R7 ack falling", 2'd2, 32'h1234_5674);
    expIrq("R7 cleared falling", 1'b1);

    // R8 edge in same cycle as clearing read
    wrReg(2'd0, 32'h4);
    extIn = 1'b1; tick(3);
    expIrq("R8 first pulse latched", 1'b0);
    extIn = 1'b0; tick(3);
    extIn = 1'b1; tick(2);
    expRead("R8 ack during edge", 2'd2, 32'h1234_5674);
    expIrq("R8 request kept", 1'b0);
    expRead("R8 second ack", 2'd2, 32'h1234_5674);
    expIrq("R8 cleared afterwards", 1'b1);

    // R5 high level, input currently 1
    wrReg(2'd0, 32'h6);
    expIrq("R5 asserted while high", 1'b0);
    expRead("R5 ack read", 2'd2, 32'h1234_5674);
    expIrq("R5 read has no effect", 1'b0);
    extIn = 1'b0;
    tick(1); expIrq("R5 still held one edge", 1'b0);
    tick(1); expIrq("R5 released", 1'b1);

    // R6 low level, input currently 0
    wrReg(2'd0, 32'h7);
    expIrq("R6 asserted while low", 1'b0);
    extIn = 1'b1;
    tick(1); expIrq("R6 still held one edge", 1'b0);
    tick(1); expIrq("R6 released", 1'b1);

    // R9 enable gating with latched edge
    wrReg(2'd0, 32'h0);
    extIn = 1'b0; tick(3);
    extIn = 1'b1; tick(4);
    expIrq("R9 disabled output high", 1'b1);
    wrReg(2'd0, 32'h4);
    expIrq("R9 latched edge appears", 1'b0);
    expRead("R9 ack", 2'd2, 32'h1234_5674);
    expIrq("R9 cleared", 1'b1);

    tick(2);
    done = 1'b1;
    summary();
  end

endmodule